// File: doc/BRIEF.md
# Clocked Slave Serial Receiver

This block receives words from a serial link on which an external master supplies both the shift clock and the data. The receiver takes one data bit on every rising edge of the shift clock, least significant bit first. When the last bit of a word is in, the word moves to a holding register that the host can read. A completion flag then rises and can raise an interrupt request. Words are 8 or 9 bits long. In 9-bit mode the top bit goes to a status bit, and the data register holds only the lower eight bits.

The shift clock and data pins are brought into the core clock domain through a synchroniser. The host sees three registers through a simple read/write port: a control register at address 0, a status register at address 1 and a data register at address 2. Any error is cleared only by dropping the continuous-receive enable and setting it again. That same action throws away any word that is only partly received.

Top module: `sslv_rx`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0, and `irq_o` is low.
- R2: When the control register has port enable (bit 0) and continuous receive (bit 2) set, and 9-bit mode (bit 1) clear, each run of 8 rising shift-clock edges delivers a word to the data register (address 2), taking bits least significant first. The same run sets the completion flag, which is status bit 2.
- R3: With 9-bit mode set, a word takes 9 rising edges. The first 8 bits go to the data register and the ninth bit goes to status bit 0. In 8-bit mode, status bit 0 reads 0 after each word.
- R4: Shift-clock edges are ignored unless port enable and continuous receive are both set. When they are ignored, the completion flag stays clear.
- R5: The single-receive control bit (bit 3) has no effect. It neither starts reception without continuous receive nor changes reception when continuous receive is set.
- R6: `irq_o` is high exactly when the completion flag is set and the interrupt enable (control bit 4) is set.
- R7: A read of the data register clears the completion flag.
- R8: If a word completes while the completion flag is still set, the overrun flag (status bit 1) is set and the new word is discarded. All further shift-clock edges are then ignored.
- R9: Clearing continuous receive clears the overrun flag and discards a partly received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Shift clock from the external master |
| sdat_i | input | 1 | Serial data from the external master |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Host read data, combinational on `reg_addr` |
| irq_o | output | 1 | Receive-complete interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data word and a two-flop synchroniser. With that configuration, every 8-bit pattern and every 9-bit pattern can be sent in one short run. The sweep therefore covers each bit position of the holding register, the ninth-bit status bit and the interrupt gating. Directed runs then cover the enable combinations, overrun with a frozen holding register, and recovery from a partly received word.

// File: rtl/sslv_pkg.sv
package sslv_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int CTRL_W = 5;

  // control layout: bit0 enable, bit1 word9, bit2 cont, bit3 single, bit4 irq_en
  typedef struct packed {
    logic irq_en;
    logic single;
    logic cont;
    logic word9;
    logic en;
  } ctrl_t;

  localparam int S_NINTH = 0;
  localparam int S_OVR   = 1;
  localparam int S_DONE  = 2;
endpackage

// File: rtl/sslv_sync.sv
module sslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic sdat_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES-1:0] sck_q, sck_d;
  logic [STAGES-1:0] dat_q, dat_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        sck_d = sck_i;
        dat_d = sdat_i;
      end
    end else begin : g_many
      always_comb begin
        sck_d = {sck_q[STAGES-2:0], sck_i};
        dat_d = {dat_q[STAGES-2:0], sdat_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      dat_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      sck_q  <= sck_d;
      dat_q  <= dat_d;
      prev_q <= sck_q[STAGES-1];
    end
  end

  assign rise_o = sck_q[STAGES-1] & ~prev_q;
  assign bit_o  = dat_q[STAGES-1];
endmodule

// File: rtl/sslv_shift.sv
module sslv_shift #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              run_i,
  input  logic              flush_i,
  input  logic              word9_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last;
  logic [WORD_W-1:0] sreg_q, sreg_d, word_c;
  logic              take, reg_en;

  assign last = word9_i ? CNT_W'(WORD_W-1) : CNT_W'(WORD_W-2);
  assign take = run_i & rise_i & ~flush_i;

  always_comb begin
    word_c = sreg_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (cnt_q == CNT_W'(i)) word_c[i] = bit_i;
    end
  end

  always_comb begin
    done_o = 1'b0;
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    if (flush_i) begin
      cnt_d  = '0;
      sreg_d = '0;
    end else if (take) begin
      if (cnt_q == last) begin
        done_o = 1'b1;
        cnt_d  = '0;
        sreg_d = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        sreg_d = word_c;
      end
    end
  end

  assign reg_en = flush_i | take;
  assign word_o = word_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else if (reg_en) begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end
endmodule

// File: rtl/sslv_regs.sv
module sslv_regs
  import sslv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                word_done_i,
  input  logic [DATA_W:0]     word_i,
  output ctrl_t               ctrl_o,
  output logic                done_o,
  output logic                ovr_o,
  output logic [DATA_W-1:0]   hold_o,
  output logic                irq_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              ninth_q, ninth_d;
  logic [DATA_W-1:0] hold_q;
  logic              data_rd, unread, cap_en, ctrl_en;

  assign data_rd = rd_i & (addr_i == A_DATA);
  assign ctrl_en = wr_i & (addr_i == A_CTRL);
  assign unread  = done_q & ~data_rd;
  assign cap_en  = word_done_i & ~unread;

  always_comb begin
    ctrl_d  = ctrl_t'(wdata_i[CTRL_W-1:0]);
    done_d  = unread;
    ovr_d   = ovr_q & ctrl_q.cont;
    ninth_d = ninth_q;
    if (word_done_i) begin
      if (unread) begin
        ovr_d = 1'b1;
      end else begin
        done_d  = 1'b1;
        ninth_d = ctrl_q.word9 & word_i[DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ninth_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      done_q  <= done_d;
      ovr_q   <= ovr_d;
      ninth_q <= ninth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= word_i[DATA_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        rdata_o[S_NINTH] = ninth_q;
        rdata_o[S_OVR]   = ovr_q;
        rdata_o[S_DONE]  = done_q;
      end
      A_DATA: rdata_o = hold_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign done_o = done_q;
  assign ovr_o  = ovr_q;
  assign hold_o = hold_q;
  assign irq_o  = done_q & ctrl_q.irq_en;
endmodule

// File: rtl/sslv_rx.sv
module sslv_rx
  import sslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sdat_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int WORD_W = DATA_W + 1;

  ctrl_t             ctrl;
  logic              rise, sbit, run, flush;
  logic              word_done, done_q, ovr_q;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] hold_q;
  logic              port_en, cont_rx, irq_en;

  assign port_en = ctrl.en;
  assign cont_rx = ctrl.cont;
  assign irq_en  = ctrl.irq_en;
  assign run     = port_en & cont_rx & ~ovr_q;
  assign flush   = ~cont_rx;

  sslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck_i),
    .sdat_i (sdat_i),
    .rise_o (rise),
    .bit_o  (sbit)
  );

  sslv_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .bit_i   (sbit),
    .run_i   (run),
    .flush_i (flush),
    .word9_i (ctrl.word9),
    .done_o  (word_done),
    .word_o  (word)
  );

  sslv_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .addr_i      (reg_addr),
    .wdata_i     (reg_wdata),
    .rdata_o     (reg_rdata),
    .word_done_i (word_done),
    .word_i      (word),
    .ctrl_o      (ctrl),
    .done_o      (done_q),
    .ovr_o       (ovr_q),
    .hold_o      (hold_q),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/sslv_rx_chk.sv
module sslv_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic              irq_o,
  input logic              port_en,
  input logic              cont_rx,
  input logic              irq_en,
  input logic              word_done,
  input logic              done_q,
  input logic              ovr_q,
  input logic [DATA_W-1:0] hold_q
);
  a_r4_idle_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && cont_rx) |-> !word_done);

  a_r2_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (done_q || ovr_q));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !word_done) |=> !done_q);

  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(hold_q));

  a_r8_no_word_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !word_done);

  a_r9_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_rx |=> !ovr_q);

  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

bind sslv_rx sslv_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .irq_o     (irq_o),
  .port_en   (port_en),
  .cont_rx   (cont_rx),
  .irq_en    (irq_en),
  .word_done (word_done),
  .done_q    (done_q),
  .ovr_q     (ovr_q),
  .hold_q    (hold_q)
);

// File: tb/sslv_rx_bench.sv
module sslv_rx_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck_i = 1'b0;
  logic          sdat_i = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sslv_rx u_sslv_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_i     (sck_i),
    .sdat_i    (sdat_i),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  // control bits: 0 enable, 1 word9, 2 cont, 3 single, 4 irq_en
  localparam logic [7:0] EN = 8'h01, W9 = 8'h02, CONT = 8'h04, ONE = 8'h08, IE = 8'h10;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdat_i = b;
    repeat (3) @(negedge clk);
    sck_i = 1'b1;
    repeat (3) @(negedge clk);
    sck_i = 1'b0;
  endtask

  task automatic send(input int val, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(val[i]);
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 0);
    peek(2'd1, v); chk("R1 stat", v, 0);
    chk("R1 irq", int'(irq_o), 0);

    // R4 enable combinations that must ignore edges
    wr(2'd0, EN);
    send(8'hA5, 8);
    peek(2'd1, v); chk("R4 en only", v, 0);
    wr(2'd0, CONT);
    send(8'hA5, 8);
    peek(2'd1, v); chk("R4 cont only", v, 0);

    // R5 single-receive bit has no effect
    wr(2'd0, EN | ONE);
    send(8'h5A, 8);
    peek(2'd1, v); chk("R5 single alone", v, 0);
    wr(2'd0, EN | CONT | ONE);
    send(8'h3C, 8);
    peek(2'd1, v); chk("R5 stat with single", v, 32'h4);
    rd(2'd2, v);   chk("R5 data with single", v, 8'h3C);

    // R2/R6/R7 sweep over every 8-bit word
    wr(2'd0, EN | CONT | IE);
    for (int w = 0; w < 256; w++) begin
      send(w, 8);
      peek(2'd1, v); chk("R2 stat done", v, 32'h4);
      chk("R6 irq high", int'(irq_o), 1);
      rd(2'd2, v);   chk("R2 data", v, w);
      peek(2'd1, v); chk("R7 done cleared", v, 0);
      chk("R6 irq low", int'(irq_o), 0);
    end

    // R6 interrupt enable off
    wr(2'd0, EN | CONT);
    send(8'h81, 8);
    peek(2'd1, v); chk("R6 done no ie", v, 32'h4);
    chk("R6 irq gated", int'(irq_o), 0);
    rd(2'd2, v);   chk("R2 data no ie", v, 8'h81);

    // R3 sweep over every 9-bit word
    wr(2'd0, EN | CONT | W9);
    for (int w = 0; w < 512; w++) begin
      send(w, 9);
      peek(2'd1, v); chk("R3 stat ninth", v, 32'h4 | ((w >> 8) & 1));
      rd(2'd2, v);   chk("R3 data", v, w & 8'hFF);
    end

    // R3 ninth bit reads 0 in 8-bit mode
    send(9'h1FF, 9);
    rd(2'd2, v);
    wr(2'd0, EN | CONT);
    send(8'h77, 8);
    peek(2'd1, v); chk("R3 ninth zero in 8-bit", v, 32'h4);
    rd(2'd2, v);   chk("R3 data 8-bit", v, 8'h77);

    // R8 overrun
    send(8'h11, 8);
    send(8'h22, 8);
    peek(2'd1, v); chk("R8 overrun set", v, 32'h6);
    send(8'h33, 8);
    rd(2'd2, v);   chk("R8 old word kept", v, 8'h11);
    peek(2'd1, v); chk("R8 ovr after read", v, 32'h2);
    send(8'h44, 8);
    peek(2'd1, v); chk("R8 transfers halted", v, 32'h2);
    rd(2'd2, v);   chk("R8 data unchanged", v, 8'h11);

    // R9 clear by dropping continuous receive
    wr(2'd0, EN);
    peek(2'd1, v); chk("R9 ovr cleared", v, 0);
    wr(2'd0, EN | CONT);
    send(8'h0F, 4);
    wr(2'd0, EN);
    wr(2'd0, EN | CONT);
    send(8'h5A, 8);
    peek(2'd1, v); chk("R9 stat after partial", v, 32'h4);
    rd(2'd2, v);   chk("R9 partial discarded", v, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule